// File: doc/BRIEF.md
# Command/Indication Subchannel Handler

This block terminates one command/indication (C/I) subchannel. The subchannel sits at a fixed bit position in a time-multiplexed serial frame. An external frame-sync pulse and a per-bit strobe give the frame timing. On the send side, the host writes a 6-bit code. The block copies that code into a shadow register at each frame start and shifts it out, MSB first, during the six slot bits. The output enable is high only for those six bits.

On the receive side, the block assembles the six slot bits of each frame into a code. A code is accepted only when it is identical in two consecutive frames. An accepted code that differs from the stored code replaces it. The block raises a sticky, maskable change flag if the difference falls inside the compared width.

A width bit selects the compared width. In 4-bit mode only the low four code bits count, while all six bits are still stored and sent. The host reaches the block through a small synchronous register port. A control register holds a bus-access request flag that is passed straight to a pin.

Top module: `cmdind_handler`

## Requirements
- R1: After reset, the transmit register (address 0) and the receive register (address 1) both read 0xFE. The control register (address 2) reads 0x00, and `irq`, `accessReq` and `serOe` are 0.
- R2: The transmit register holds the code in bits 7:2, the width bit in bit 1 and the enable bit in bit 0. The code is sampled at the bit strobe that carries frame sync. It is sent MSB first on `serOut` during frame bits SLOT_START to SLOT_START+5. `serOe` is high exactly during those bits. A write made mid-frame is first sent in the following frame.
- R3: All six code bits are sent whatever the width bit says.
- R4: A received code updates the receive register (bits 7:2) only when the same code arrived in the previous frame. A code seen in a single frame leaves the register unchanged.
- R5: Receive-register bits 1:0 read back the current width and enable bits of the transmit register.
- R6: With width bit 1 and enable bit 1, an accepted code that differs from the stored code in any bit sets the change flag. `irq` equals the flag.
- R7: With width bit 0, an accepted code that differs only in code bits 5:4 is stored but does not set the flag. A difference in bits 3:0 sets it.
- R8: With enable bit 0, an accepted change is stored but never sets the flag.
- R9: The flag is sticky across further changes, which still update the stored code. A read of the receive register clears it, and a set in the same cycle wins over the clear. The flag is visible at control bit 1.
- R10: Control bit 0 is a writable access-request flag driven on `accessReq`. Writes to address 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameSync | input | 1 | Marks frame bit 0, valid together with bitStrobe |
| bitStrobe | input | 1 | One-cycle pulse per serial bit |
| serIn | input | 1 | Serial receive data, sampled on bitStrobe |
| serOut | output | 1 | Serial transmit data |
| serOe | output | 1 | Transmit enable, high during the slot |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (reading address 1 clears the flag) |
| regAddr | input | 2 | Register address: 0 transmit, 1 receive, 2 control |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data, combinational from regAddr |
| irq | output | 1 | Change interrupt |
| accessReq | output | 1 | Bus-access request flag |

## Verification
Most internal faults show up at the ports within one or two frames. A wrong bit counter or wrong shadow timing shows up in the first frame, as a misplaced `serOe` window or wrong `serOut` bits. A broken debounce candidate or stored code shows up in the receive register read after the second matching frame. A wrong compare mask or wrong enable gating shows up as `irq` set or missing at the end of that frame's slot. A wrong flag clear shows up on the `irq` pin one cycle after the host read.

// File: rtl/ci_pkg.sv
package ci_pkg;
  localparam int CODE_W = 6;
  localparam int NARROW_W = 4;
  localparam int POS_W = $clog2(CODE_W);
  localparam logic [CODE_W-1:0] CODE_IDLE = '1;
  localparam logic [1:0] ADDR_TX = 2'd0;
  localparam logic [1:0] ADDR_RX = 2'd1;
  localparam logic [1:0] ADDR_CTL = 2'd2;

  typedef struct packed {
    logic frameStart;
    logic slotBit;
    logic rxDone;
  } ciStrobes_t;
endpackage

// File: rtl/ci_ctl.sv
module ci_ctl
  import ci_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int SLOT_START = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameSync,
  input  logic             bitStrobe,
  output ciStrobes_t       strb,
  output logic [POS_W-1:0] txPos,
  output logic             txActive
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] SLOT_LO = CNT_W'(SLOT_START);
  localparam logic [CNT_W-1:0] SLOT_HI = CNT_W'(SLOT_START + CODE_W - 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(CODE_W - 1);

  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] curIdx;
  logic             syncNow;
  logic             rxInSlot;
  logic [POS_W-1:0] rxPos;

  assign syncNow = bitStrobe && frameSync;
  assign curIdx = syncNow ? '0 : bitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (bitStrobe) begin
      if (syncNow) bitCnt <= CNT_W'(1);
      else if (bitCnt == LAST_BIT) bitCnt <= '0;
      else bitCnt <= bitCnt + CNT_W'(1);
    end
  end

  assign rxInSlot = (curIdx >= SLOT_LO) && (curIdx <= SLOT_HI);
  assign rxPos = POS_W'(curIdx - SLOT_LO);

  assign txActive = (bitCnt >= SLOT_LO) && (bitCnt <= SLOT_HI);
  assign txPos = txActive ? POS_W'(bitCnt - SLOT_LO) : '0;

  always_comb begin
    strb.frameStart = syncNow;
    strb.slotBit = bitStrobe && rxInSlot;
    strb.rxDone = bitStrobe && rxInSlot && (rxPos == LAST_POS);
  end
endmodule

// File: rtl/ci_dp.sv
module ci_dp
  import ci_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ciStrobes_t       strb,
  input  logic [POS_W-1:0] txPos,
  input  logic             serIn,
  input  logic             regWe,
  input  logic             regRe,
  input  logic [1:0]       regAddr,
  input  logic [7:0]       regWdata,
  output logic [7:0]       regRdata,
  output logic             serOut,
  output logic             irq,
  output logic             accessReq
);
  localparam logic [CODE_W-1:0] MASK_WIDE = '1;
  localparam logic [CODE_W-1:0] MASK_NARROW = CODE_W'((1 << NARROW_W) - 1);

  logic [CODE_W-1:0] txCode, txShadow, cand, rxCode, rxWord, diffMask;
  logic [CODE_W-2:0] rxShift;
  logic              wideSel, intEn, chgFlag, reqAcc;
  logic              confirm, raise, rdRx;
  logic [POS_W-1:0]  txSel;

  assign rxWord = {rxShift, serIn};
  assign diffMask = wideSel ? MASK_WIDE : MASK_NARROW;
  assign confirm = strb.rxDone && (rxWord == cand) && (rxWord != rxCode);
  assign raise = confirm && intEn && (((rxWord ^ rxCode) & diffMask) != '0);
  assign rdRx = regRe && (regAddr == ADDR_RX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txCode   <= CODE_IDLE;
      wideSel  <= 1'b1;
      intEn    <= 1'b0;
      txShadow <= CODE_IDLE;
      rxShift  <= '0;
      cand     <= CODE_IDLE;
      rxCode   <= CODE_IDLE;
      chgFlag  <= 1'b0;
      reqAcc   <= 1'b0;
    end else begin
      if (regWe && regAddr == ADDR_TX) {txCode, wideSel, intEn} <= regWdata;
      if (regWe && regAddr == ADDR_CTL) reqAcc <= regWdata[0];
      if (strb.frameStart) txShadow <= txCode;
      if (strb.slotBit) rxShift <= rxWord[CODE_W-2:0];
      if (strb.rxDone) cand <= rxWord;
      if (confirm) rxCode <= rxWord;
      if (raise) chgFlag <= 1'b1;
      else if (rdRx) chgFlag <= 1'b0;
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_TX:  regRdata = {txCode, wideSel, intEn};
      ADDR_RX:  regRdata = {rxCode, wideSel, intEn};
      ADDR_CTL: regRdata = {6'b0, chgFlag, reqAcc};
      default:  regRdata = 8'h00;
    endcase
  end

  assign txSel = POS_W'(CODE_W - 1) - txPos;
  assign serOut = txShadow[txSel];
  assign irq = chgFlag;
  assign accessReq = reqAcc;
endmodule

// File: rtl/cmdind_handler.sv
module cmdind_handler
  import ci_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int SLOT_START = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameSync,
  input  logic       bitStrobe,
  input  logic       serIn,
  output logic       serOut,
  output logic       serOe,
  input  logic       regWe,
  input  logic       regRe,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       irq,
  output logic       accessReq
);
  ciStrobes_t       strb;
  logic [POS_W-1:0] txPos;

  ci_ctl #(.FRAME_BITS(FRAME_BITS), .SLOT_START(SLOT_START)) u_ctl (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .bitStrobe(bitStrobe),
    .strb(strb), .txPos(txPos), .txActive(serOe)
  );

  ci_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .txPos(txPos), .serIn(serIn),
    .regWe(regWe), .regRe(regRe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .serOut(serOut), .irq(irq), .accessReq(accessReq)
  );
endmodule

// File: rtl/ci_chk.sv
module ci_chk
  import ci_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       bitStrobe,
  input logic       regWe,
  input logic       regRe,
  input logic [1:0] regAddr,
  input logic       serOut,
  input logic       serOe,
  input logic       irq,
  input logic       accessReq,
  input logic       rxDone
);
  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRe && regAddr == ADDR_RX && !rxDone) |=> !irq);
  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(regRe && regAddr == ADDR_RX)) |=> irq);
  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(rxDone));
  // R2
  ser_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitStrobe |=> ($stable(serOut) && $stable(serOe)));
  // R10
  access_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWe && regAddr == ADDR_CTL) |=> $stable(accessReq));
endmodule

bind cmdind_handler ci_chk u_chk (
  .clk(clk), .rstN(rstN), .bitStrobe(bitStrobe), .regWe(regWe), .regRe(regRe),
  .regAddr(regAddr), .serOut(serOut), .serOe(serOe), .irq(irq),
  .accessReq(accessReq), .rxDone(strb.rxDone)
);

// File: tb/cmdind_handler_tb.sv
`timescale 1ns/1ps
module cmdind_handler_tb;
  localparam int FB = 16;
  localparam int SS = 4;
  localparam int SE = SS + 5;

  logic clk = 1'b0, rstN = 1'b0;
  logic frameSync = 0, bitStrobe = 0, serIn = 0, regWe = 0, regRe = 0;
  logic [1:0] regAddr = 0;
  logic [7:0] regWdata = 0;
  logic serOut, serOe, irq, accessReq;
  logic [7:0] regRdata;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [5:0] mTx = 6'h3F, mCand = 6'h3F, mRx = 6'h3F;
  logic mWide = 1, mIen = 0, mStat = 0, mReq = 0;

  always #2.5 clk = ~clk;

  cmdind_handler #(.FRAME_BITS(FB), .SLOT_START(SS)) u_dut (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .bitStrobe(bitStrobe),
    .serIn(serIn), .serOut(serOut), .serOe(serOe), .regWe(regWe), .regRe(regRe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .irq(irq),
    .accessReq(accessReq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic expRaise(input logic [5:0] nw, input logic [5:0] old,
                                    input logic wide, input logic ien);
    logic [5:0] m;
    m = wide ? 6'h3F : 6'h0F;
    return ien && (((nw ^ old) & m) != 0);
  endfunction

  task automatic modelWrite(input logic [1:0] a, input logic [7:0] d);
    if (a == 2'd0) {mTx, mWide, mIen} = d;
    if (a == 2'd2) mReq = d[0];
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); regWe = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 0;
    modelWrite(a, d);
  endtask

  task automatic hostRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); regRe = 1; regAddr = a; #1 d = regRdata;
    @(negedge clk); regRe = 0;
    if (a == 2'd1) mStat = 0;
  endtask

  task automatic checkRx(input string req);
    logic [7:0] d;
    hostRead(2'd1, d);
    check(d == {mRx, mWide, mIen}, req, d, {mRx, mWide, mIen});
    #1 check(irq == 1'b0, "R9 clear on read", irq, 0);
  endtask

  task automatic runFrame(input logic [5:0] rxc, input int wbit, input logic [7:0] wdata,
                          input string req);
    logic [5:0] shadow, seen;
    bit oeOk;
    shadow = mTx; seen = 0; oeOk = 1;
    for (int b = 0; b < FB; b++) begin
      @(negedge clk);
      regWe = 0;
      bitStrobe = 1; frameSync = (b == 0);
      serIn = (b >= SS && b <= SE) ? rxc[5 - (b - SS)] : 1'($urandom_range(1));
      #1;
      if (b >= SS && b <= SE) begin
        seen[5 - (b - SS)] = serOut;
        if (!serOe) oeOk = 0;
      end else if (serOe) oeOk = 0;
      @(negedge clk);
      bitStrobe = 0; frameSync = 0;
      if (b == SE) begin
        if (rxc == mCand && rxc != mRx) begin
          if (expRaise(rxc, mRx, mWide, mIen)) mStat = 1;
          mRx = rxc;
        end
        mCand = rxc;
      end
      if (b == wbit) begin
        regWe = 1; regAddr = 2'd0; regWdata = wdata;
        modelWrite(2'd0, wdata);
      end
    end
    @(negedge clk); regWe = 0;
    check(oeOk, "R2 oe window", oeOk, 1);
    check(seen == shadow, req, seen, shadow);
    check(irq == mStat, "R6/R7/R8/R9 irq", irq, mStat);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R1 reset values
    check(irq == 0 && accessReq == 0 && serOe == 0, "R1 pins", {irq, accessReq, serOe}, 0);
    hostRead(2'd0, d); check(d == 8'hFE, "R1 tx reg", d, 8'hFE);
    hostRead(2'd1, d); check(d == 8'hFE, "R1 rx reg", d, 8'hFE);
    hostRead(2'd2, d); check(d == 8'h00, "R1 ctl reg", d, 8'h00);

    // R2 R5 wide mode, enable on
    hostWrite(2'd0, {6'h2A, 1'b1, 1'b1});
    runFrame(6'h3F, -1, 0, "R2 tx code");
    checkRx("R5 readback");

    // R4 debounce: one frame does not update
    runFrame(6'h15, -1, 0, "R2 tx");
    check(irq == 0, "R4 single frame no irq", irq, 0);
    checkRx("R4 single frame no update");
    runFrame(6'h15, -1, 0, "R2 tx");
    check(irq == 1, "R6 change irq", irq, 1);
    checkRx("R4 confirmed code");
    // R4 glitch in between
    runFrame(6'h22, -1, 0, "R2 tx");
    runFrame(6'h15, -1, 0, "R2 tx");
    checkRx("R4 glitch ignored");

    // R7 R3 narrow mode
    hostWrite(2'd0, {6'h0C, 1'b0, 1'b1});
    runFrame(6'h25, -1, 0, "R3 narrow tx full code");
    runFrame(6'h25, -1, 0, "R3 narrow tx full code");
    check(irq == 0, "R7 upper bits no irq", irq, 0);
    checkRx("R7 upper bits stored");
    runFrame(6'h26, -1, 0, "R3 tx");
    runFrame(6'h26, -1, 0, "R3 tx");
    check(irq == 1, "R7 low bits irq", irq, 1);
    checkRx("R7 code");

    // R8 enable off
    hostWrite(2'd0, {6'h11, 1'b1, 1'b0});
    runFrame(6'h01, -1, 0, "R2 tx");
    runFrame(6'h01, -1, 0, "R2 tx");
    check(irq == 0, "R8 masked", irq, 0);
    checkRx("R8 code stored");

    // R9 sticky over two changes
    hostWrite(2'd0, {6'h11, 1'b1, 1'b1});
    runFrame(6'h02, -1, 0, "R2 tx");
    runFrame(6'h02, -1, 0, "R2 tx");
    runFrame(6'h03, -1, 0, "R2 tx");
    runFrame(6'h03, -1, 0, "R2 tx");
    check(irq == 1, "R9 sticky", irq, 1);
    hostRead(2'd2, d); check(d[1] == 1, "R9 status bit", d, 2);
    checkRx("R9 latest code");

    // R2 mid-frame write takes effect next frame
    runFrame(6'h03, SS + 2, {6'h30, 1'b1, 1'b1}, "R2 old code this frame");
    runFrame(6'h03, -1, 0, "R2 new code next frame");

    // R10 access request, write to rx ignored
    hostWrite(2'd2, 8'h01);
    #1 check(accessReq == 1, "R10 set", accessReq, 1);
    hostWrite(2'd1, 8'h00);
    checkRx("R10 rx write ignored");
    hostWrite(2'd2, 8'h00);
    #1 check(accessReq == 0, "R10 clear", accessReq, 0);

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [5:0] pool [4];
      logic [5:0] rc;
      int wb;
      pool[0] = 6'h05; pool[1] = 6'h35; pool[2] = 6'h0A; pool[3] = 6'h3F;
      rc = pool[$urandom_range(3)];
      wb = ($urandom_range(3) == 0) ? int'($urandom_range(FB - 1)) : -1;
      runFrame(rc, wb, 8'($urandom), "R2 random tx");
      if ($urandom_range(2) == 0) checkRx("R4 random rx");
    end

    done = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule